// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block models a byte-wide static RAM with a nonvolatile shadow array of the same size. Host accesses go through a synchronous interface with three active-low strobes (chip enable, write enable, output enable), an address bus and a data bus. Ordinary reads and writes touch only the volatile array. The shadow array changes only during a store.

Two transfers move data between the arrays. A store copies every volatile byte into the shadow. A recall copies the shadow back into the volatile array. Software starts a transfer by reading six fixed addresses in order. A recall also starts on its own when reset is released. During a transfer the controller moves one byte per clock at the start of the window and keeps `busy` high for the whole programmed duration. While `busy` is high, host accesses are locked out.

Durations are given in microseconds and turned into clock cycles through a cycles-per-microsecond parameter, so a bench can shrink them. A window is never shorter than the array depth. The 64 Kbit configuration uses `ADDR_W = 13`. The default is smaller so that elaboration stays light.

Top module: `nvsram_ctrl`

## Requirements
- R1: The volatile array holds 2**ADDR_W bytes of DATA_W bits. An access is a cycle with `ce_n` low. It is a write when `we_n` is also low and a read otherwise. A write stores `wdata` at `addr`.
- R2: A read with `oe_n` low returns `rdata` equal to the addressed byte, with `rvalid` high, in the cycle after the access. In every other cycle, `rvalid` is low and `rdata` is zero.
- R3: Six back-to-back reads at `STORE_SEQ[0]` through `STORE_SEQ[5]`, in that order, start a store. The level of `oe_n` during those reads has no effect on recognition. Cycles with `ce_n` high do not count as breaks.
- R4: Six back-to-back reads at `RECALL_SEQ[0]` through `RECALL_SEQ[5]`, in that order, start a recall. The level of `oe_n` has no effect on recognition.
- R5: A write, or a read at an address other than the expected next entry, abandons a partial sequence. Such a read at entry 0 counts as the first entry of a new attempt.
- R6: After a store starts, `busy` stays high for exactly max(STORE_US*CYC_PER_US, 2**ADDR_W) rising edges. When it falls, the shadow array holds the volatile contents from the start of the store.
- R7: A software recall keeps `busy` high for exactly max(RECALL_US*CYC_PER_US, 2**ADDR_W) edges. Afterwards every volatile byte equals the shadow byte.
- R8: `busy` is high during reset. After release, a recall holds `busy` high for max(PWRUP_US*CYC_PER_US, 2**ADDR_W) edges. Before any store, the shadow holds 0xFF in every byte, so every address then reads 0xFF.
- R9: While `busy` is high, writes have no effect on the volatile array, and reads give `rvalid` low and `rdata` zero.
- R10: Writes outside a store never change the shadow array. A recall after writes without a store restores the last stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; release triggers the power-up recall |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, zero when not valid |
| rvalid | output | 1 | Read data valid |
| busy | output | 1 | Transfer in progress; host accesses locked out |

## Verification
The hardest state to reach is a transfer started under exact control: six reads in strict order, with nothing in between that the detector counts as a break. Random reads therefore avoid every address that appears in either sequence. Directed streams then cover the break and restart cases:
- a write inside the sequence;
- a foreign read inside the sequence;
- a repeated first entry.

Accesses are also issued in the first cycles of a store window. The bench confirms they are discarded and that the window still closes on the exact edge.

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int unsigned ADDR_W        = 11,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CYC_PER_US    = 200,
  parameter int unsigned STORE_US      = 10000,
  parameter int unsigned RECALL_US     = 20,
  parameter int unsigned PWRUP_US      = 550,
  parameter int unsigned STORE_SEQ [6] = '{'h4E2, 'h1B7, 'h6C9, 'h236, 'h7D1, 'h0A8},
  parameter int unsigned RECALL_SEQ[6] = '{'h4E2, 'h1B7, 'h6C9, 'h236, 'h7D1, 'h52F}
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              busy
);

  localparam int unsigned DEPTH      = 1 << ADDR_W;
  localparam int unsigned SEQ_LEN    = 6;
  localparam int unsigned STORE_RAW  = STORE_US * CYC_PER_US;
  localparam int unsigned RECALL_RAW = RECALL_US * CYC_PER_US;
  localparam int unsigned PWRUP_RAW  = PWRUP_US * CYC_PER_US;
  localparam int unsigned STORE_CYC  = (STORE_RAW  < DEPTH) ? DEPTH : STORE_RAW;
  localparam int unsigned RECALL_CYC = (RECALL_RAW < DEPTH) ? DEPTH : RECALL_RAW;
  localparam int unsigned PWRUP_CYC  = (PWRUP_RAW  < DEPTH) ? DEPTH : PWRUP_RAW;
  localparam int unsigned MAX_A      = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > PWRUP_CYC) ? MAX_A : PWRUP_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {M_IDLE, M_STORE, M_RECALL} mode_t;

  mode_t             mode;
  logic [CNT_W-1:0]  cnt, lim;
  logic [ADDR_W:0]   ptr;
  logic [2:0]        st_cnt, rc_cnt, st_nxt, rc_nxt;
  logic [DATA_W-1:0] vol [DEPTH];
  logic [DATA_W-1:0] nv  [DEPTH];
  logic              rd_acc, wr_acc, copy_on, store_go, recall_go;
  logic [ADDR_W-1:0] ptr_a;

  initial begin
    for (int i = 0; i < DEPTH; i++) nv[i] = '1;
  end

  assign busy     = (mode != M_IDLE);
  assign rd_acc   = !busy && !ce_n && we_n;
  assign wr_acc   = !busy && !ce_n && !we_n;
  assign copy_on  = !ptr[ADDR_W];
  assign ptr_a    = ptr[ADDR_W-1:0];

  always_comb begin
    if (addr == ADDR_W'(STORE_SEQ[st_cnt]))   st_nxt = st_cnt + 3'd1;
    else if (addr == ADDR_W'(STORE_SEQ[0]))   st_nxt = 3'd1;
    else                                      st_nxt = 3'd0;
    if (addr == ADDR_W'(RECALL_SEQ[rc_cnt]))  rc_nxt = rc_cnt + 3'd1;
    else if (addr == ADDR_W'(RECALL_SEQ[0]))  rc_nxt = 3'd1;
    else                                      rc_nxt = 3'd0;
  end

  assign store_go  = rd_acc && (st_nxt == 3'(SEQ_LEN));
  assign recall_go = rd_acc && (rc_nxt == 3'(SEQ_LEN)) && !store_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= M_RECALL;
      cnt    <= '0;
      lim    <= CNT_W'(PWRUP_CYC);
      ptr    <= '0;
      st_cnt <= '0;
      rc_cnt <= '0;
    end else if (busy) begin
      if (copy_on) ptr <= ptr + 1'b1;
      if (cnt == lim - 1'b1) mode <= M_IDLE;
      else                   cnt  <= cnt + 1'b1;
    end else if (store_go || recall_go) begin
      mode   <= store_go ? M_STORE : M_RECALL;
      lim    <= store_go ? CNT_W'(STORE_CYC) : CNT_W'(RECALL_CYC);
      cnt    <= '0;
      ptr    <= '0;
      st_cnt <= '0;
      rc_cnt <= '0;
    end else if (wr_acc) begin
      st_cnt <= '0;
      rc_cnt <= '0;
    end else if (rd_acc) begin
      st_cnt <= st_nxt;
      rc_cnt <= rc_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && mode == M_STORE && copy_on) nv[ptr_a] <= vol[ptr_a];
    if (rst_n && mode == M_RECALL && copy_on) vol[ptr_a] <= nv[ptr_a];
    else if (rst_n && wr_acc)                 vol[addr]  <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_acc && !oe_n) begin
      rvalid <= 1'b1;
      rdata  <= vol[addr];
    end else begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end
  end

  AST_INVALID_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);                                             // R2
  AST_START_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!ce_n && we_n));                                // R3
  AST_WRITE_BREAKS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ce_n && !we_n) |=> (st_cnt == 3'd0 && rc_cnt == 3'd0));   // R5
  AST_COPY_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ptr == (ADDR_W+1)'(DEPTH));                          // R6
  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < lim);                                                  // R7
  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rvalid);                                                    // R9

endmodule

// File: tb/tb_nvsram_ctrl.sv
module tb_nvsram_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int STORE_N  = 10000;
  localparam int RECALL_N = 20;
  localparam int PWRUP_N  = 550;
  localparam int unsigned SSEQ[6] = '{3, 12, 5, 10, 6, 9};
  localparam int unsigned RSEQ[6] = '{3, 12, 5, 10, 6, 15};
  localparam int unsigned SAFE[9] = '{0, 1, 2, 4, 7, 8, 11, 13, 14};

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rvalid, busy;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] vol_m [N];
  logic [DW-1:0] nv_m  [N];

  always #2.5 clk = ~clk;

  nvsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CYC_PER_US(1), .STORE_US(10000),
                .RECALL_US(20), .PWRUP_US(550), .STORE_SEQ(SSEQ), .RECALL_SEQ(RSEQ)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a, input bit oe_low);
    return oe_low ? int'(vol_m[a]) : 0;
  endfunction

  task automatic rd(input int a, input bit oe_low, output int d, output bit v);
    ce_n = 0; we_n = 1; oe_n = !oe_low; addr = AW'(a);
    @(posedge clk); @(negedge clk);
    d = int'(rdata); v = rvalid;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wr(input int a, input int d, input bit take);
    ce_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); wdata = DW'(d);
    @(posedge clk); @(negedge clk);
    ce_n = 1; we_n = 1;
    if (take) vol_m[a] = DW'(d);
  endtask

  task automatic rd_chk(input string req, input int a, input bit oe_low);
    int d; bit v;
    rd(a, oe_low, d, v);
    chk(req, d, exp_rd(a, oe_low));
    chk(req, int'(v), int'(oe_low));
  endtask

  task automatic seq_reads(input bit rec, input int from, input int to, input bit oe_low);
    int d; bit v;
    for (int k = from; k <= to; k++) rd(rec ? int'(RSEQ[k]) : int'(SSEQ[k]), oe_low, d, v);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (busy && n < 20000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, d, a, r; bit v;
    r = $urandom(32'h5eed);
    for (int i = 0; i < N; i++) nv_m[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R8 busy in reset", int'(busy), 1);
    chk("R2 rvalid in reset", int'(rvalid), 0);
    rst_n = 1;
    wait_busy(n);
    chk("R8 power-up window", n, PWRUP_N);
    for (int i = 0; i < N; i++) vol_m[i] = nv_m[i];
    for (int i = 0; i < N; i++) rd_chk("R8 initial shadow", i, 1);

    for (int i = 0; i < N; i++) wr(i, $urandom_range(255), 1);
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(1)) wr($urandom_range(N - 1), $urandom_range(255), 1);
      else rd_chk("R1 R2 random", int'(SAFE[$urandom_range(8)]), 1'($urandom_range(1)));
    end
    rd_chk("R2 oe high", 2, 0);

    for (int i = 0; i < N; i++) nv_m[i] = vol_m[i];
    seq_reads(0, 0, 5, 0);
    chk("R3 store starts oe high", int'(busy), 1);
    a = 7;
    wr(a, int'(~vol_m[a]), 0);
    rd(a, 1, d, v);
    chk("R9 read value while busy", d, 0);
    chk("R9 rvalid while busy", int'(v), 0);
    wait_busy(n);
    chk("R6 store window", n + 2, STORE_N);
    rd_chk("R9 write ignored", a, 1);

    for (int i = 0; i < N; i++) wr(i, $urandom_range(255), 1);
    rd_chk("R1 new data", 5, 1);
    seq_reads(1, 0, 5, 1);
    chk("R4 recall starts", int'(busy), 1);
    wait_busy(n);
    chk("R7 recall window", n, RECALL_N);
    for (int i = 0; i < N; i++) vol_m[i] = nv_m[i];
    for (int i = 0; i < N; i++) rd_chk("R7 R10 restored", i, 1);

    seq_reads(0, 0, 4, 1);
    wr(0, 8'h5A, 1);
    seq_reads(0, 5, 5, 1);
    chk("R5 write breaks sequence", int'(busy), 0);
    seq_reads(0, 0, 4, 0);
    rd(1, 0, d, v);
    seq_reads(0, 5, 5, 0);
    chk("R5 foreign read breaks", int'(busy), 0);
    seq_reads(1, 0, 4, 0);
    rd(0, 1, d, v);
    seq_reads(1, 5, 5, 0);
    chk("R5 recall broken", int'(busy), 0);

    seq_reads(0, 0, 1, 1);
    seq_reads(0, 0, 5, 1);
    chk("R5 restart at first entry", int'(busy), 1);
    for (int i = 0; i < N; i++) nv_m[i] = vol_m[i];
    wait_busy(n);
    chk("R6 second store", n, STORE_N);
    wr(9, 8'h33, 1);
    seq_reads(1, 0, 5, 0);
    wait_busy(n);
    chk("R7 second recall", n, RECALL_N);
    for (int i = 0; i < N; i++) vol_m[i] = nv_m[i];
    rd_chk("R6 stored write visible", 0, 1);
    rd_chk("R10 unstored write lost", 9, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule